// File: doc/BRIEF.md
# Event-Capture SMI Status Register

This block is a 32-bit status and enable register for a USB host controller's configuration space. It watches a set of host-controller control levels and strobes, and sets a sticky flag for each one that changes. The watched signals are eight per-port ownership bits, a strobe for writes to the power-state field, the asynchronous and periodic schedule enables, the configure flag and the halted indication. Software reads the whole word and clears any flag by writing a one to it.

The flags, the sampled copies of the watched inputs and the enable bits all live in an always-on reset domain. A reset of the main logic, or a power-state change of the function, therefore leaves them intact. Each flag has an enable bit, and all eight port flags share one enable. The AND of each flag with its enable is ORed into a single registered SMI request. That request is the only state held in the main reset domain.

Top module: `smi_evt_status`

## Requirements
- R1: Port n (n = 1..8, input bit n-1 of `port_own_i`) sets status bit 21+n (bits 22..29) when its level changes, from 0 to 1 or from 1 to 0. The flag is readable after the clock edge at which the changed level is first sampled.
- R2: A high `pwr_state_wr_i` in a cycle sets status bit 21 at that clock edge.
- R3: A change of `async_en_i` sets bit 20, a change of `periodic_en_i` sets bit 19 and a change of `cfg_flag_i` sets bit 18, in either direction.
- R4: Bit 17 sets when `halted_i` rises while `run_stop_i` is 0. A rise of `halted_i` while `run_stop_i` is 1 does not set it, and neither does a fall.
- R5: A write with `wr_en_i` high clears every status bit (29:17) whose data bit is 1 and leaves those written 0 unchanged. After the always-on reset the read value is 00000000h.
- R6: When a set event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R7: Bits 31:30 and 16:6 always read 0, and writes to them have no effect.
- R8: Bits 5:0 are read/write enables: bit 5 covers all port flags, bit 4 covers bit 21, bit 3 covers bit 20, bit 2 covers bit 19, bit 1 covers bit 18 and bit 0 covers bit 17.
- R9: `smi_o` is 1 one clock after any status bit and its enable are both 1, and 0 one clock after no such pair exists.
- R10: With `rst_ni` low, `smi_o` is 0 and status and enable bits hold their values. With `aon_rst_ni` low, all status and enable bits read 0.
- R11: A level already present on a watched input when the always-on reset is released is not counted as a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Main domain reset, active low, asynchronous |
| aon_rst_ni | input | 1 | Always-on domain reset, active low, asynchronous |
| port_own_i | input | 8 | Port ownership levels, ports 1..8 |
| pwr_state_wr_i | input | 1 | Strobe: software wrote the power-state field |
| async_en_i | input | 1 | Asynchronous schedule enable level |
| periodic_en_i | input | 1 | Periodic schedule enable level |
| cfg_flag_i | input | 1 | Configure flag level |
| halted_i | input | 1 | Controller halted indication |
| run_stop_i | input | 1 | Run/stop control level |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read value |
| smi_o | output | 1 | SMI request |

## Verification
The assertions assume that every watched input and the write port are synchronous to `clk_i`. They also assume that `run_stop_i` already holds its final value in the cycle in which `halted_i` rises. They check the power-state flag, clearing and set priority only on bit 21, because a strobe there needs no history. The bench changes all inputs on the falling edge, changes `run_stop_i` together with or before `halted_i`, and releases both resets on a falling edge.

// File: rtl/smi_evt_pkg.sv
`timescale 1ns/1ps
package smi_evt_pkg;
  parameter int NUM_PORTS = 8;
  parameter int DATA_W    = 32;
  // status flag vector index i maps to register bit STAT_LSB + i
  parameter int STAT_LSB  = 17;
  parameter int NUM_MISC  = 5;                       // halt, cfg, periodic, async, pwr
  parameter int STAT_W    = NUM_MISC + NUM_PORTS;    // 13
  parameter int EN_W      = NUM_MISC + 1;            // one shared port enable
  parameter int MON_W     = NUM_PORTS + 4;           // levels to watch for change

  typedef enum int {
    IDX_HALT = 0, IDX_CFG = 1, IDX_PER = 2, IDX_ASYNC = 3, IDX_PWR = 4, IDX_PORT0 = 5
  } stat_idx_e;
endpackage

// File: rtl/smi_edge_det.sv
`timescale 1ns/1ps
module smi_edge_det #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] tgl_o
);
  logic [W-1:0] prev_q;
  logic         primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= d_i;
      primed_q <= 1'b1;
    end
  end

  // no change reported until a first sample exists
  assign tgl_o = primed_q ? (d_i ^ prev_q) : '0;
endmodule

// File: rtl/smi_sticky_flags.sv
`timescale 1ns/1ps
module smi_sticky_flags #(
  parameter int W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (q & ~clr_i) | set_i;   // set beats clear
  end

  assign q_o = q;
endmodule

// File: rtl/smi_evt_status.sv
`timescale 1ns/1ps
module smi_evt_status
  import smi_evt_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 aon_rst_ni,
  input  logic [NUM_PORTS-1:0] port_own_i,
  input  logic                 pwr_state_wr_i,
  input  logic                 async_en_i,
  input  logic                 periodic_en_i,
  input  logic                 cfg_flag_i,
  input  logic                 halted_i,
  input  logic                 run_stop_i,
  input  logic                 wr_en_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic                 smi_o
);
  logic [MON_W-1:0]  mon, tgl;
  logic [STAT_W-1:0] set, clr, flags, en_vec;
  logic [EN_W-1:0]   en_q;
  logic              smi_q;

  // watched levels: 0 halt, 1 cfg, 2 periodic, 3 async, 4.. ports
  assign mon = {port_own_i, async_en_i, periodic_en_i, cfg_flag_i, halted_i};

  smi_edge_det #(.W(MON_W)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (aon_rst_ni),
    .d_i    (mon),
    .tgl_o  (tgl)
  );

  always_comb begin
    set            = '0;
    set[IDX_HALT]  = tgl[0] & halted_i & ~run_stop_i;   // rise after stop only
    set[IDX_CFG]   = tgl[1];
    set[IDX_PER]   = tgl[2];
    set[IDX_ASYNC] = tgl[3];
    set[IDX_PWR]   = pwr_state_wr_i;
    set[STAT_W-1:IDX_PORT0] = tgl[MON_W-1:4];
  end

  assign clr = wr_en_i ? wr_data_i[STAT_LSB +: STAT_W] : '0;

  smi_sticky_flags #(.W(STAT_W)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (aon_rst_ni),
    .set_i  (set),
    .clr_i  (clr),
    .q_o    (flags)
  );

  always_ff @(posedge clk_i or negedge aon_rst_ni) begin
    if (!aon_rst_ni)  en_q <= '0;
    else if (wr_en_i) en_q <= wr_data_i[EN_W-1:0];
  end

  // spread the shared port enable over all port flags
  for (genvar i = 0; i < STAT_W; i++) begin : g_en
    if (i < IDX_PORT0) begin : g_misc
      assign en_vec[i] = en_q[i];
    end else begin : g_port
      assign en_vec[i] = en_q[EN_W-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smi_q <= 1'b0;
    else         smi_q <= |(flags & en_vec);
  end

  always_comb begin
    rd_data_o                      = '0;
    rd_data_o[STAT_LSB +: STAT_W]  = flags;
    rd_data_o[EN_W-1:0]            = en_q;
  end

  assign smi_o = smi_q;
endmodule

// File: rtl/smi_evt_status_chk.sv
`timescale 1ns/1ps
module smi_evt_status_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        aon_rst_ni,
  input logic        pwr_state_wr_i,
  input logic        wr_en_i,
  input logic [31:0] wr_data_i,
  input logic [31:0] rd_data_o,
  input logic        smi_o
);
  logic smi_src;
  assign smi_src = (|rd_data_o[29:22] & rd_data_o[5]) | (|(rd_data_o[21:17] & rd_data_o[4:0]));

  a_r2_pwr_sets: assert property (@(posedge clk_i) disable iff (!aon_rst_ni)
    (pwr_state_wr_i && !wr_en_i) |=> rd_data_o[21]);

  a_r5_w1c_clears: assert property (@(posedge clk_i) disable iff (!aon_rst_ni)
    (wr_en_i && wr_data_i[21] && !pwr_state_wr_i) |=> !rd_data_o[21]);

  a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!aon_rst_ni)
    (wr_en_i && wr_data_i[21] && pwr_state_wr_i) |=> rd_data_o[21]);

  a_r7_reserved_zero: assert property (@(posedge clk_i) disable iff (!aon_rst_ni)
    (rd_data_o[31:30] == 2'b00) && (rd_data_o[16:6] == 11'h0));

  a_r9_smi_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni || !aon_rst_ni)
    1'b1 |=> (smi_o == $past(smi_src)));

  a_r10_main_rst_keeps: assert property (@(posedge clk_i) disable iff (!aon_rst_ni)
    (!rst_ni && !wr_en_i) |=>
      ((rd_data_o[29:17] & $past(rd_data_o[29:17])) == $past(rd_data_o[29:17])));

  a_r10_main_rst_smi_low: assert property (@(posedge clk_i)
    !rst_ni |-> !smi_o);
endmodule

bind smi_evt_status smi_evt_status_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .aon_rst_ni     (aon_rst_ni),
  .pwr_state_wr_i (pwr_state_wr_i),
  .wr_en_i        (wr_en_i),
  .wr_data_i      (wr_data_i),
  .rd_data_o      (rd_data_o),
  .smi_o          (smi_o)
);

// File: tb/tb_smi_evt_status.sv
`timescale 1ns/1ps
module tb_smi_evt_status;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0, aon_rst_ni = 1'b0;
  logic [7:0]  port_own_i = '0;
  logic        pwr_state_wr_i = 0, async_en_i = 0, periodic_en_i = 0;
  logic        cfg_flag_i = 0, halted_i = 0, run_stop_i = 1;
  logic        wr_en_i = 0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        smi_o;

  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [31:0] ST_MASK = 32'h3FFE_0000;

  always #5 clk_i = ~clk_i;

  smi_evt_status dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic reg_wr(input logic [31:0] d);
    wr_en_i = 1; wr_data_i = d; tick(); wr_en_i = 0; wr_data_i = '0;
  endtask

  task automatic t_reset;
    chk("R5 reset value", rd_data_o, 32'h0);
    chk("R10 smi after reset", {31'h0, smi_o}, 32'h0);
  endtask

  task automatic t_ports;
    logic [31:0] exp = '0;
    for (int i = 0; i < 8; i++) begin
      port_own_i[i] = 1'b1; tick();
      exp |= 32'h1 << (22 + i);
      chk("R1 port rise", rd_data_o, exp);
    end
    reg_wr(ST_MASK);
    chk("R5 clear all", rd_data_o, 32'h0);
    for (int i = 0; i < 8; i++) begin
      port_own_i[i] = 1'b0; tick();
      chk("R1 port fall", rd_data_o, 32'h1 << (22 + i));
      reg_wr(32'h1 << (22 + i));
    end
    chk("R1 cleared", rd_data_o, 32'h0);
  endtask

  task automatic t_misc;
    pwr_state_wr_i = 1; tick(); pwr_state_wr_i = 0;
    chk("R2 pwr write", rd_data_o, 32'h0020_0000);
    async_en_i = 1; tick();
    chk("R3 async", rd_data_o, 32'h0030_0000);
    periodic_en_i = 1; tick();
    chk("R3 periodic", rd_data_o, 32'h0038_0000);
    cfg_flag_i = 1; tick();
    chk("R3 cfg", rd_data_o, 32'h003C_0000);
    reg_wr(32'h0000_0000);
    chk("R5 write zero keeps", rd_data_o, 32'h003C_0000);
    reg_wr(32'h0010_0000);
    chk("R5 clear one bit", rd_data_o, 32'h002C_0000);
    reg_wr(ST_MASK);
    async_en_i = 0; periodic_en_i = 0; cfg_flag_i = 0; tick();
    chk("R3 falls", rd_data_o, 32'h001C_0000);
    reg_wr(ST_MASK);
    chk("R3 cleared", rd_data_o, 32'h0);
  endtask

  task automatic t_halt;
    halted_i = 1; tick();              // run_stop still 1: other cause
    chk("R4 halt other cause", rd_data_o, 32'h0);
    halted_i = 0; tick();
    chk("R4 halt fall", rd_data_o, 32'h0);
    run_stop_i = 0; halted_i = 1; tick();
    chk("R4 halt after stop", rd_data_o, 32'h0002_0000);
    reg_wr(32'h0002_0000);
    halted_i = 0; run_stop_i = 1; tick();
    chk("R4 cleared", rd_data_o, 32'h0);
  endtask

  task automatic t_set_wins;
    pwr_state_wr_i = 1; wr_en_i = 1; wr_data_i = 32'h0020_0000; tick();
    pwr_state_wr_i = 0; wr_en_i = 0; wr_data_i = '0;
    chk("R6 set over clear", rd_data_o, 32'h0020_0000);
    reg_wr(32'h0020_0000);
  endtask

  task automatic t_reserved;
    reg_wr(32'hC001_FFC0);
    chk("R7 reserved ignored", rd_data_o, 32'h0);
  endtask

  task automatic t_smi;
    reg_wr(32'h0000_003F);
    chk("R8 enables read", rd_data_o, 32'h0000_003F);
    reg_wr(32'h0000_0010);             // only pwr enabled
    port_own_i[3] = 1; tick(2);
    chk("R9 masked port no smi", {31'h0, smi_o}, 32'h0);
    pwr_state_wr_i = 1; tick(); pwr_state_wr_i = 0;
    chk("R9 smi not yet", {31'h0, smi_o}, 32'h0);
    tick();
    chk("R9 smi pwr", {31'h0, smi_o}, 32'h1);
    reg_wr(32'h0020_0000 | 32'h10);
    tick();
    chk("R9 smi drops", {31'h0, smi_o}, 32'h0);
    reg_wr(32'h0000_0020);             // port shared enable
    tick();
    chk("R8 port enable smi", {31'h0, smi_o}, 32'h1);
    // main reset
    rst_ni = 0; #1;
    chk("R10 smi in main reset", {31'h0, smi_o}, 32'h0);
    tick(2);
    chk("R10 state kept", rd_data_o, 32'h0200_0020);
    rst_ni = 1; tick();
    chk("R10 smi after main reset", {31'h0, smi_o}, 32'h1);
  endtask

  task automatic t_aon;
    port_own_i = 8'hFF; async_en_i = 1; halted_i = 1; run_stop_i = 0;
    aon_rst_ni = 0; #1;
    chk("R10 aon clears", rd_data_o, 32'h0);
    tick(2); aon_rst_ni = 1; tick(3);
    chk("R11 no spurious", rd_data_o, 32'h0);
    port_own_i = 8'h00; tick();
    chk("R1 after aon", rd_data_o, 32'h3FC0_0000);
  endtask

  initial begin
    tick(3); rst_ni = 1; aon_rst_ni = 1; tick(2);
    t_reset();
    t_ports();
    t_misc();
    t_halt();
    t_set_wins();
    t_reserved();
    t_smi();
    t_aon();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule